// File: doc/BRIEF.md
# SPI Word FIFO Status and Interrupt Unit

This block sits between the register decoder of an SPI controller and its shift engine. It keeps two word queues: a transmit queue written from the bus side and drained by the shift engine, and a receive queue filled by the shift engine and drained from the bus side. Both queues are 16 words deep by default. From their fill levels, and from two sticky event bits, it builds an 8-bit status vector. An 8-bit enable register shares that vector's layout, and the single interrupt line is the OR of every status bit that is also enabled.

Software reads status, enable and both fill counters directly. A write of ones to the status register clears the sticky event bits. A two-bit soft-reset strobe empties either queue or both. The shift engine signals the end of each burst with a one-cycle pulse, which latches the transfer-complete bit. All outputs are registered state or combinational decodes of it, so they change one clock after the triggering input is sampled.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset both fill counters read 0, status reads 8'h01 (only TX empty), the enable register reads 8'h00 and the interrupt line is low.
- R2: Each queue returns words in the order they were accepted. Its counter rises by one per accepted push and falls by one per pop. A push and a pop in the same cycle leave the count unchanged, and this also holds when the queue is full.
- R3: Status bit 0 (TX empty) is set when the TX count is 0, and bit 2 (TX full) is set when it is 16. A TX write while the queue is full is discarded: neither the count nor the stored words change.
- R4: Status bit 1 (TX half-full) and bit 4 (RX half-full) are set while the respective count is 8 or more.
- R5: Status bit 3 (RX ready) is set while the RX count is nonzero, and bit 5 (RX full) is set when it is 16. A pop from an empty queue is ignored.
- R6: Status bit 6 (RX overflow) is set when the engine pushes into a full RX queue without a pop in the same cycle. The word is dropped, and the bit stays set afterwards.
- R7: Status bit 7 (transfer complete) is set one cycle after the completion pulse and stays set. If a pulse and a clearing write arrive in the same cycle, the bit stays set.
- R8: A status write clears bit 7 and bit 6 where the written data holds a one. Ones written to bits 0 to 5, and zeros anywhere, have no effect.
- R9: Soft-reset bit 0 empties the TX queue and bit 1 empties the RX queue; the RX reset also clears the overflow bit. A soft reset wins over a push in the same cycle, and it leaves the other queue untouched.
- R10: The enable register reads back what was last written, and the interrupt line is high exactly when some status bit and its enable bit are both one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_push | input | 1 | Bus writes a word into the TX queue |
| tx_push_data | input | 32 | Word written to the TX queue |
| tx_pop | input | 1 | Shift engine takes the TX head word |
| tx_head | output | 32 | Current TX head word |
| rx_push | input | 1 | Shift engine delivers a received word |
| rx_push_data | input | 32 | Received word |
| rx_pop | input | 1 | Bus reads the RX data port (pops one word) |
| rx_head | output | 32 | Current RX head word |
| xfer_done | input | 1 | One-cycle burst-complete pulse from the engine |
| stat_wr | input | 1 | Write strobe for the status register |
| stat_wdata | input | 8 | Write-one-to-clear data for the status register |
| ien_wr | input | 1 | Write strobe for the enable register |
| ien_wdata | input | 8 | New enable value |
| soft_rst | input | 2 | Bit 0 empties TX, bit 1 empties RX |
| status | output | 8 | Status vector |
| int_en | output | 8 | Enable register |
| tx_count | output | 5 | TX fill level |
| rx_count | output | 5 | RX fill level |
| irq | output | 1 | Interrupt request |

## Verification
Both queues are stepped through every fill level from 0 to 16 and back. At each level the full status vector is compared with a value computed from the counts. This separates threshold mistakes (7 against 8, 15 against 16) from ordering mistakes in the stored data. One extra push at full is tried twice: with a simultaneous pop, where it must be absorbed, and alone, where it must be dropped and flagged. Every one of the 256 enable values is applied against two different status patterns, so a wrong bit in the interrupt OR shows up as a specific mismatch. Clearing writes, soft resets and completion pulses are issued alone and also colliding in one cycle, which exposes a wrong priority between set and clear.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;

  // Status / enable bit positions (software decodes these)
  localparam int unsigned ST_TX_EMPTY = 0;
  localparam int unsigned ST_TX_HALF  = 1;
  localparam int unsigned ST_TX_FULL  = 2;
  localparam int unsigned ST_RX_READY = 3;
  localparam int unsigned ST_RX_HALF  = 4;
  localparam int unsigned ST_RX_FULL  = 5;
  localparam int unsigned ST_RX_OVF   = 6;
  localparam int unsigned ST_XFER_END = 7;
  localparam int unsigned ST_BITS     = 8;

  typedef logic [ST_BITS-1:0] stat_vec_t;

  // Bits that only a write of one can clear
  localparam stat_vec_t STICKY_MASK = stat_vec_t'((1 << ST_RX_OVF) | (1 << ST_XFER_END));

  // Soft-reset strobe bit positions
  localparam int unsigned SR_TX = 0;
  localparam int unsigned SR_RX = 1;

  function automatic logic lvl_half(input int unsigned fill, input int unsigned depth);
    return fill >= (depth / 2);
  endfunction

  function automatic logic lvl_full(input int unsigned fill, input int unsigned depth);
    return fill == depth;
  endfunction

  function automatic logic lvl_empty(input int unsigned fill);
    return fill == 0;
  endfunction

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty,
  output logic             push_drop
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    fill_q;

  // Named internal events
  logic pop_ok, push_ok;

  function automatic logic [AW-1:0] ptr_step(input logic [AW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full      = (fill_q == CW'(DEPTH));
  assign empty     = (fill_q == '0);
  assign pop_ok    = pop && !empty && !clr;
  assign push_ok   = push && !clr && (!full || pop_ok);
  assign push_drop = push && !clr && full && !pop_ok;
  assign head      = mem[rd_ptr];
  assign count     = fill_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_step(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end

  // R3: the fill level never exceeds the depth
  p_no_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);

  // R2: a lone accepted push raises the count by exactly one
  p_push_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> (count == $past(count) + 1'b1));

  // R2: a push and pop together leave the count unchanged
  p_both_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(count));

  // R9: a clear empties the queue on the next cycle
  p_clr_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  // R5: popping an empty queue with no push leaves it empty
  p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);

endmodule

// File: rtl/spi_stat_irq.sv
module spi_stat_irq
  import spi_fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] tx_fill,
  input  logic [CW-1:0] rx_fill,
  input  logic          rx_drop,
  input  logic          rx_clr,
  input  logic          xfer_done,
  input  logic          stat_wr,
  input  stat_vec_t     stat_wdata,
  input  logic          ien_wr,
  input  stat_vec_t     ien_wdata,
  output stat_vec_t     status,
  output stat_vec_t     int_en,
  output logic          irq
);

  logic      ovf_q, done_q;
  stat_vec_t ien_q;
  stat_vec_t w1c;

  // Named internal events
  logic ovf_clear_req, done_clear_req;

  assign w1c            = stat_wr ? (stat_wdata & STICKY_MASK) : '0;
  assign ovf_clear_req  = w1c[ST_RX_OVF];
  assign done_clear_req = w1c[ST_XFER_END];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else if (rx_clr) begin
      ovf_q <= 1'b0;
    end else if (rx_drop) begin
      ovf_q <= 1'b1;
    end else if (ovf_clear_req) begin
      ovf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (xfer_done) begin
      done_q <= 1'b1;
    end else if (done_clear_req) begin
      done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (ien_wr) ien_q <= ien_wdata;
  end

  always_comb begin
    status              = '0;
    status[ST_TX_EMPTY] = lvl_empty(32'(tx_fill));
    status[ST_TX_HALF]  = lvl_half(32'(tx_fill), DEPTH);
    status[ST_TX_FULL]  = lvl_full(32'(tx_fill), DEPTH);
    status[ST_RX_READY] = !lvl_empty(32'(rx_fill));
    status[ST_RX_HALF]  = lvl_half(32'(rx_fill), DEPTH);
    status[ST_RX_FULL]  = lvl_full(32'(rx_fill), DEPTH);
    status[ST_RX_OVF]   = ovf_q;
    status[ST_XFER_END] = done_q;
  end

  assign int_en = ien_q;
  assign irq    = |(status & ien_q);

  // R7: a completion pulse always lands in the status bit
  p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> status[ST_XFER_END]);

  // R6: overflow is sticky until a clear or an RX soft reset
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[ST_RX_OVF] && !ovf_clear_req && !rx_clr) |=> status[ST_RX_OVF]);

  // R6: a dropped word raises overflow unless RX is being reset
  p_ovf_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drop && !rx_clr) |=> status[ST_RX_OVF]);

  // R3: TX empty and TX full are never reported together
  p_tx_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({status[ST_TX_EMPTY], status[ST_TX_FULL]}));

  // R8: a status write does not touch the level-derived bits
  p_levels_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && $stable(tx_fill) && $stable(rx_fill)) |-> $stable(status[5:0]));

endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_fifo_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_push,
  input  logic [WIDTH-1:0] tx_push_data,
  input  logic             tx_pop,
  output logic [WIDTH-1:0] tx_head,
  input  logic             rx_push,
  input  logic [WIDTH-1:0] rx_push_data,
  input  logic             rx_pop,
  output logic [WIDTH-1:0] rx_head,
  input  logic             xfer_done,
  input  logic             stat_wr,
  input  logic [7:0]       stat_wdata,
  input  logic             ien_wr,
  input  logic [7:0]       ien_wdata,
  input  logic [1:0]       soft_rst,
  output logic [7:0]       status,
  output logic [7:0]       int_en,
  output logic [CW-1:0]    tx_count,
  output logic [CW-1:0]    rx_count,
  output logic             irq
);

  // Per-queue signals, index 0 = TX, 1 = RX
  logic             q_push [2];
  logic             q_pop  [2];
  logic             q_clr  [2];
  logic [WIDTH-1:0] q_din  [2];
  logic [WIDTH-1:0] q_head [2];
  logic [CW-1:0]    q_cnt  [2];
  logic             q_full [2];
  logic             q_empty[2];
  logic             q_drop [2];

  assign q_push[0] = tx_push;
  assign q_din[0]  = tx_push_data;
  assign q_pop[0]  = tx_pop;
  assign q_clr[0]  = soft_rst[SR_TX];
  assign q_push[1] = rx_push;
  assign q_din[1]  = rx_push_data;
  assign q_pop[1]  = rx_pop;
  assign q_clr[1]  = soft_rst[SR_RX];

  for (genvar g = 0; g < 2; g++) begin : g_queue
    spi_word_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (q_clr[g]),
      .push      (q_push[g]),
      .push_data (q_din[g]),
      .pop       (q_pop[g]),
      .head      (q_head[g]),
      .count     (q_cnt[g]),
      .full      (q_full[g]),
      .empty     (q_empty[g]),
      .push_drop (q_drop[g])
    );
  end

  assign tx_head  = q_head[0];
  assign rx_head  = q_head[1];
  assign tx_count = q_cnt[0];
  assign rx_count = q_cnt[1];

  stat_vec_t st_int, ien_int;

  spi_stat_irq #(.DEPTH(DEPTH)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_fill    (q_cnt[0]),
    .rx_fill    (q_cnt[1]),
    .rx_drop    (q_drop[1]),
    .rx_clr     (q_clr[1]),
    .xfer_done  (xfer_done),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .ien_wr     (ien_wr),
    .ien_wdata  (ien_wdata),
    .status     (st_int),
    .int_en     (ien_int),
    .irq        (irq)
  );

  assign status = st_int;
  assign int_en = ien_int;

  // R10: with nothing enabled the interrupt line stays low
  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == '0) |-> !irq);

  // R5: RX ready agrees with the RX queue's own empty indication
  p_rx_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_RX_READY] == !q_empty[1]);

  // R3: TX full agrees with the TX queue's own full indication
  p_tx_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_TX_FULL] == q_full[0]);

  // R9: an RX soft reset leaves the TX count alone when TX is idle
  p_rx_rst_iso_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst == 2'b10 && !tx_push && !tx_pop) |=> $stable(tx_count));

endmodule

// File: tb/spi_fifo_irq_unit_tb.sv
`timescale 1ns/1ps
module spi_fifo_irq_unit_tb_top;

  localparam int unsigned D = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [31:0] tx_push_data = '0, rx_push_data = '0;
  logic [31:0] tx_head, rx_head;
  logic        xfer_done = 0, stat_wr = 0, ien_wr = 0;
  logic [7:0]  stat_wdata = '0, ien_wdata = '0;
  logic [1:0]  soft_rst = '0;
  logic [7:0]  status, int_en;
  logic [4:0]  tx_count, rx_count;
  logic        irq;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  spi_fifo_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop), .tx_head(tx_head),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_pop(rx_pop), .rx_head(rx_head),
    .xfer_done(xfer_done), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .ien_wr(ien_wr), .ien_wdata(ien_wdata), .soft_rst(soft_rst),
    .status(status), .int_en(int_en), .tx_count(tx_count), .rx_count(rx_count), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected status from the requirements' bit map
  function automatic logic [7:0] exp_st(input int txc, input int rxc, input bit ovf, input bit tc);
    return {tc, ovf, rxc == D, rxc >= D/2, rxc != 0, txc == D, txc >= D/2, txc == 0};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    xfer_done = 0; stat_wr = 0; ien_wr = 0; soft_rst = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status, 8'h01);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 int_en", int_en, 0);
    chk("R1 irq", irq, 0);

    // R3 R4 TX fill sweep, one extra push at full
    for (int i = 0; i <= D; i++) begin
      tx_push = 1; tx_push_data = 32'hA000_0000 + i;
      tick();
      chk("R3 tx_count", tx_count, (i < D) ? i + 1 : D);
      chk("R4 R3 status tx fill", status, exp_st((i < D) ? i + 1 : D, 0, 0, 0));
    end
    // R2 TX drain in order; the dropped word must not appear
    for (int k = 0; k < D; k++) begin
      chk("R2 tx order", tx_head, 32'hA000_0000 + k);
      tx_pop = 1;
      tick();
      chk("R2 tx_count", tx_count, D - 1 - k);
      chk("R4 status tx drain", status, exp_st(D - 1 - k, 0, 0, 0));
    end
    // R5 pop on empty TX ignored
    tx_pop = 1; tick();
    chk("R5 tx empty pop", tx_count, 0);

    // R4 R5 RX fill sweep
    for (int i = 0; i < D; i++) begin
      rx_push = 1; rx_push_data = 32'h5500_0000 + i;
      tick();
      chk("R5 rx_count", rx_count, i + 1);
      chk("R4 R5 status rx fill", status, exp_st(0, i + 1, 0, 0));
    end
    // R6 push into full RX
    rx_push = 1; rx_push_data = 32'hDEAD_BEEF; tick();
    chk("R6 rx_count after drop", rx_count, D);
    chk("R6 overflow set", status, exp_st(0, D, 1, 0));
    // R2 R6 drain; overflow stays
    for (int k = 0; k < D; k++) begin
      chk("R2 rx order", rx_head, 32'h5500_0000 + k);
      rx_pop = 1; tick();
      chk("R6 status sticky", status, exp_st(0, D - 1 - k, 1, 0));
    end
    rx_pop = 1; tick();
    chk("R5 rx empty pop", rx_count, 0);
    // R8 writes to level bits have no effect
    stat_wr = 1; stat_wdata = 8'h3F; tick();
    chk("R8 level bits ignored", status, exp_st(0, 0, 1, 0));
    stat_wr = 1; stat_wdata = 8'h00; tick();
    chk("R8 zero write ignored", status, exp_st(0, 0, 1, 0));
    stat_wr = 1; stat_wdata = 8'h40; tick();
    chk("R8 ovf cleared", status, exp_st(0, 0, 0, 0));

    // R2 push+pop on full RX: no overflow, count kept
    for (int i = 0; i < D; i++) begin
      rx_push = 1; rx_push_data = 32'h7700_0000 + i; tick();
    end
    rx_push = 1; rx_push_data = 32'h7700_00FF; rx_pop = 1; tick();
    chk("R2 full push+pop count", rx_count, D);
    chk("R2 full push+pop no ovf", status, exp_st(0, D, 0, 0));
    chk("R2 head after push+pop", rx_head, 32'h7700_0001);
    // R6 then R9: overflow, RX soft reset clears both
    rx_push = 1; tick();
    chk("R6 ovf again", status[6], 1);
    tx_push = 1; tx_push_data = 32'h1; tick();
    soft_rst = 2'b10; rx_push = 1; tick();
    chk("R9 rx reset count", rx_count, 0);
    chk("R9 rx reset status", status, exp_st(1, 0, 0, 0));
    chk("R9 tx untouched", tx_count, 1);
    // R9 TX soft reset beats push
    soft_rst = 2'b01; tx_push = 1; rx_push = 1; rx_push_data = 32'h9; tick();
    chk("R9 tx reset count", tx_count, 0);
    chk("R9 rx untouched", rx_count, 1);
    soft_rst = 2'b11; tick();
    chk("R9 both reset", status, 8'h01);

    // R7 transfer complete
    xfer_done = 1; tick();
    chk("R7 tc set", status, exp_st(0, 0, 0, 1));
    tick();
    chk("R7 tc holds", status[7], 1);
    xfer_done = 1; stat_wr = 1; stat_wdata = 8'h80; tick();
    chk("R7 set beats clear", status[7], 1);
    stat_wr = 1; stat_wdata = 8'hFF; tick();
    chk("R8 tc cleared", status, 8'h01);

    // R10 enable sweep against two status patterns
    for (int p = 0; p < 2; p++) begin
      logic [7:0] st;
      if (p == 1) begin
        xfer_done = 1; rx_push = 1; rx_push_data = 32'h3; tick();
      end
      st = (p == 0) ? 8'h01 : 8'h89;
      chk("R10 pattern", status, st);
      for (int e = 0; e < 256; e++) begin
        ien_wr = 1; ien_wdata = 8'(e); tick();
        chk("R10 int_en readback", int_en, e);
        chk("R10 irq", irq, |(st & 8'(e)));
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule